// File: doc/BRIEF.md
# Nested Exception Escalation Detector

This block watches the delivery of exception handlers in a processor core and decides what happens to each new exception that arrives. A delivery window opens when the core reports that it has started delivering a handler for some vector. The window closes when the core reports that the delivery is complete. An exception that arrives outside the window is passed on unchanged.

An exception raised inside the window is judged by the classes of two exceptions: the one being delivered and the new one. Every vector falls into one of three classes: benign, contributory or page fault. Most class pairs are handled one after the other. Three pairs cannot be handled that way, and those become a double fault on vector 8 with a zero error code. An exception raised while the double-fault handler itself is being delivered puts the core into shutdown. Shutdown is sticky and silences every output until reset.

Each decision appears on registered outputs one cycle after the exception strobe. The core then starts the next delivery itself. Gate fetch, stack pushes and the wider priority logic stay outside this block.

Top module: `dfault_escalator`

## Requirements
- R1: After reset is released, out_valid, out_vec, out_err_valid, out_err and shutdown are all 0.
- R2: Vector classes are fixed. Vectors 0, 10, 11, 12 and 13 are contributory. Vector 14 is the page-fault class. Every other vector is benign.
- R3: An exception raised while no delivery window is open produces out_valid one cycle later. It carries out_vec equal to the exception vector and out_err_valid equal to exc_has_err. out_err equals exc_err when exc_has_err is 1 and is 0 otherwise.
- R4: Three class pairs, taken as (vector being delivered, new vector), escalate inside the window: contributory then contributory, page fault then contributory, and page fault then page fault. An escalation produces out_vec 8 with out_err_valid 1 and out_err 0.
- R5: Every other class pair inside the window passes the new exception through exactly as in R3.
- R6: A window opens in the cycle after dlv_start and records dlv_vec. It closes in the cycle after dlv_done. An exception in the same cycle as dlv_start is judged against the state before that strobe.
- R7: An exception raised while the window is open for vector 8 raises shutdown in the next cycle and produces no out_valid.
- R8: Once shutdown is set, it stays set until reset. While it is set, out_valid, out_vec, out_err_valid and out_err stay 0.
- R9: out_valid is a single-cycle pulse for each accepted exception strobe. It is never asserted without an exception strobe in the previous cycle.
- R10: When dlv_start and dlv_done arrive in the same cycle, the start wins and the window is open for the new vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dlv_start | input | 1 | Handler delivery has started |
| dlv_vec | input | 8 | Vector whose handler is being delivered |
| dlv_done | input | 1 | Handler delivery has completed |
| exc_valid | input | 1 | New exception strobe |
| exc_vec | input | 8 | Vector of the new exception |
| exc_has_err | input | 1 | New exception carries an error code |
| exc_err | input | 32 | Error code of the new exception |
| out_valid | output | 1 | A vector is to be delivered |
| out_vec | output | 8 | Vector to deliver |
| out_err_valid | output | 1 | An error code accompanies the vector |
| out_err | output | 32 | Error code to push |
| shutdown | output | 1 | Sticky shutdown indication |

## Verification
The bench walks all nine class pairs inside an open window, using the edge vectors 0, 13, 14 and a benign vector. A design with a wrong pair table would either escalate a serial pair or pass a double fault through with the original vector. The bench also tests the strobe boundaries: an exception in the same cycle as the start strobe, an exception in the cycle right after the done strobe, and start and done arriving together. An off-by-one window would judge these against the wrong delivery. Finally, it faults during vector-8 delivery and keeps driving exceptions afterwards. A non-sticky shutdown, or a leaked out_valid during shutdown, is caught before a reset finally clears the state.

// File: rtl/dfe_pkg.sv
// Shared types for the escalation detector.
package dfe_pkg;
    typedef enum logic [1:0] {
        CLS_BENIGN  = 2'd0,
        CLS_CONTRIB = 2'd1,
        CLS_PAGE    = 2'd2
    } exc_class_e;
endpackage

// File: rtl/dfe_classify.sv
// Maps a vector to its exception class. Purely combinational.
// Assumes the contributory set is vector ZERO_VEC plus the range CON_LO..CON_HI.
module dfe_classify
    import dfe_pkg::*;
#(
    parameter int VEC_W    = 8,
    parameter int ZERO_VEC = 0,
    parameter int CON_LO   = 10,
    parameter int CON_HI   = 13,
    parameter int PF_VEC   = 14
) (
    input  logic [VEC_W-1:0] vec,
    output exc_class_e       cls
);
    localparam logic [VEC_W-1:0] Z_V  = VEC_W'(ZERO_VEC);
    localparam logic [VEC_W-1:0] LO_V = VEC_W'(CON_LO);
    localparam logic [VEC_W-1:0] HI_V = VEC_W'(CON_HI);
    localparam logic [VEC_W-1:0] PF_V = VEC_W'(PF_VEC);

    // Class lookup: page fault first, then contributory, else benign.
    always_comb begin
        if (vec == PF_V)
            cls = CLS_PAGE;
        else if (vec == Z_V || (vec >= LO_V && vec <= HI_V))
            cls = CLS_CONTRIB;
        else
            cls = CLS_BENIGN;
    end
endmodule

// File: rtl/dfe_window.sv
// Tracks whether a handler delivery is in progress and which vector it is for.
// Assumes the start strobe outranks the done strobe in the same cycle.
module dfe_window #(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dlv_start,
    input  logic [VEC_W-1:0] dlv_vec,
    input  logic             dlv_done,
    output logic             win_open,
    output logic [VEC_W-1:0] win_vec
);
    // Window state: opened by start, closed by done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_open <= 1'b0;
            win_vec  <= '0;
        end else if (dlv_start) begin
            win_open <= 1'b1;
            win_vec  <= dlv_vec;
        end else if (dlv_done) begin
            win_open <= 1'b0;
        end
    end
endmodule

// File: rtl/dfe_decide.sv
// Judges a new exception against the delivery in progress and registers the outcome.
// Assumes classes are supplied by the caller; shutdown holds until reset.
module dfe_decide
    import dfe_pkg::*;
#(
    parameter int VEC_W  = 8,
    parameter int ERR_W  = 32,
    parameter int DF_VEC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_open,
    input  logic [VEC_W-1:0] win_vec,
    input  exc_class_e       first_cls,
    input  exc_class_e       second_cls,
    input  logic             exc_valid,
    input  logic [VEC_W-1:0] exc_vec,
    input  logic             exc_has_err,
    input  logic [ERR_W-1:0] exc_err,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_vec,
    output logic             out_err_valid,
    output logic [ERR_W-1:0] out_err,
    output logic             shutdown
);
    localparam logic [VEC_W-1:0] DF_V = VEC_W'(DF_VEC);

    logic escalate;
    logic in_df;

    // Pair rule: which (first, second) class pairs cannot run serially.
    always_comb begin
        escalate = 1'b0;
        unique case (first_cls)
            CLS_CONTRIB: escalate = (second_cls == CLS_CONTRIB);
            CLS_PAGE:    escalate = (second_cls == CLS_CONTRIB) || (second_cls == CLS_PAGE);
            default:     escalate = 1'b0;
        endcase
        in_df = win_open && (win_vec == DF_V);
    end

    // Registered outcome plus sticky shutdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_vec       <= '0;
            out_err_valid <= 1'b0;
            out_err       <= '0;
            shutdown      <= 1'b0;
        end else begin
            out_valid     <= 1'b0;
            out_vec       <= '0;
            out_err_valid <= 1'b0;
            out_err       <= '0;
            if (!shutdown && exc_valid) begin
                if (in_df) begin
                    shutdown <= 1'b1;
                end else if (win_open && escalate) begin
                    out_valid     <= 1'b1;
                    out_vec       <= DF_V;
                    out_err_valid <= 1'b1;
                end else begin
                    out_valid     <= 1'b1;
                    out_vec       <= exc_vec;
                    out_err_valid <= exc_has_err;
                    out_err       <= exc_has_err ? exc_err : '0;
                end
            end
        end
    end
endmodule

// File: rtl/dfault_escalator.sv
// Top: decides serial handling, double-fault escalation or shutdown for nested exceptions.
// Assumes one exception strobe per cycle and a core that reports delivery start/done.
module dfault_escalator
    import dfe_pkg::*;
#(
    parameter int VEC_W  = 8,
    parameter int ERR_W  = 32,
    parameter int DF_VEC = 8,
    parameter int PF_VEC = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dlv_start,
    input  logic [VEC_W-1:0] dlv_vec,
    input  logic             dlv_done,
    input  logic             exc_valid,
    input  logic [VEC_W-1:0] exc_vec,
    input  logic             exc_has_err,
    input  logic [ERR_W-1:0] exc_err,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_vec,
    output logic             out_err_valid,
    output logic [ERR_W-1:0] out_err,
    output logic             shutdown
);
    logic             win_open;
    logic [VEC_W-1:0] win_vec;
    exc_class_e       cls_pair [2];
    logic [VEC_W-1:0] cls_in   [2];

    assign cls_in[0] = win_vec;
    assign cls_in[1] = exc_vec;

    dfe_window #(.VEC_W(VEC_W)) u_window (
        .clk(clk), .rst_n(rst_n), .dlv_start(dlv_start), .dlv_vec(dlv_vec),
        .dlv_done(dlv_done), .win_open(win_open), .win_vec(win_vec)
    );

    // One classifier for the delivered vector, one for the new vector.
    for (genvar gi = 0; gi < 2; gi++) begin : g_cls
        dfe_classify #(.VEC_W(VEC_W), .PF_VEC(PF_VEC)) u_cls (
            .vec(cls_in[gi]), .cls(cls_pair[gi])
        );
    end

    dfe_decide #(.VEC_W(VEC_W), .ERR_W(ERR_W), .DF_VEC(DF_VEC)) u_decide (
        .clk(clk), .rst_n(rst_n), .win_open(win_open), .win_vec(win_vec),
        .first_cls(cls_pair[0]), .second_cls(cls_pair[1]),
        .exc_valid(exc_valid), .exc_vec(exc_vec), .exc_has_err(exc_has_err),
        .exc_err(exc_err), .out_valid(out_valid), .out_vec(out_vec),
        .out_err_valid(out_err_valid), .out_err(out_err), .shutdown(shutdown)
    );
endmodule

// File: rtl/dfault_escalator_chk.sv
// Checker for the escalation detector; attached by bind below.
module dfault_escalator_chk #(
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             exc_valid,
    input logic [VEC_W-1:0] exc_vec,
    input logic             win_open,
    input logic             out_valid,
    input logic [VEC_W-1:0] out_vec,
    input logic             shutdown
);
    AST_SHUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |=> shutdown); // R8
    AST_SHUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> !out_valid); // R8
    AST_OUT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_valid) |=> !out_valid); // R9
    AST_OUTSIDE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && !win_open && !shutdown) |=> (out_valid && out_vec == $past(exc_vec))); // R3
    AST_SHUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!shutdown && !(exc_valid && win_open)) |=> !shutdown); // R7
endmodule

bind dfault_escalator dfault_escalator_chk #(.VEC_W(VEC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_vec(exc_vec),
    .win_open(win_open), .out_valid(out_valid), .out_vec(out_vec), .shutdown(shutdown)
);

// File: tb/dfault_escalator_test.sv
module dfault_escalator_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        dlv_start, dlv_done, exc_valid, exc_has_err;
    logic [7:0]  dlv_vec, exc_vec;
    logic [31:0] exc_err;
    logic        out_valid, out_err_valid, shutdown;
    logic [7:0]  out_vec;
    logic [31:0] out_err;

    int checks = 0;
    int errors = 0;

    // model state
    logic       m_win;
    logic [7:0] m_vec;
    logic       m_shut;
    logic       e_valid, e_errv;
    logic [7:0] e_vec;
    logic [31:0] e_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    dfault_escalator uut (
        .clk(clk), .rst_n(rst_n), .dlv_start(dlv_start), .dlv_vec(dlv_vec),
        .dlv_done(dlv_done), .exc_valid(exc_valid), .exc_vec(exc_vec),
        .exc_has_err(exc_has_err), .exc_err(exc_err), .out_valid(out_valid),
        .out_vec(out_vec), .out_err_valid(out_err_valid), .out_err(out_err),
        .shutdown(shutdown)
    );

    function automatic int cls(input logic [7:0] v);
        if (v == 8'd14) return 2;
        if (v == 8'd0 || (v >= 8'd10 && v <= 8'd13)) return 1;
        return 0;
    endfunction

    function automatic logic esc(input logic [7:0] a, input logic [7:0] b);
        return (cls(a) == 1 && cls(b) == 1) || (cls(a) == 2 && cls(b) != 0);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, predict, check after the edge.
    task automatic cyc(input logic s, input logic [7:0] sv, input logic d,
                       input logic e, input logic [7:0] ev, input logic eh,
                       input logic [31:0] ec, input string req);
        dlv_start = s; dlv_vec = sv; dlv_done = d;
        exc_valid = e; exc_vec = ev; exc_has_err = eh; exc_err = ec;
        e_valid = 0; e_vec = 0; e_errv = 0; e_err = 0;
        if (!m_shut && e) begin
            if (m_win && m_vec == 8'd8) m_shut = 1;
            else if (m_win && esc(m_vec, ev)) begin
                e_valid = 1; e_vec = 8'd8; e_errv = 1; e_err = 0;
            end else begin
                e_valid = 1; e_vec = ev; e_errv = eh; e_err = eh ? ec : 0;
            end
        end
        if (s) begin m_win = 1; m_vec = sv; end
        else if (d) m_win = 0;
        @(posedge clk);
        @(negedge clk);
        check(req, 64'(out_valid), 64'(e_valid), "out_valid");
        check(req, 64'(out_vec), 64'(e_vec), "out_vec");
        check(req, 64'(out_err_valid), 64'(e_errv), "out_err_valid");
        check(req, 64'(out_err), 64'(e_err), "out_err");
        check(req, 64'(shutdown), 64'(m_shut), "shutdown");
    endtask

    task automatic do_reset();
        rst_n = 0;
        dlv_start = 0; dlv_vec = 0; dlv_done = 0;
        exc_valid = 0; exc_vec = 0; exc_has_err = 0; exc_err = 0;
        m_win = 0; m_vec = 0; m_shut = 0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [7:0] pv [4];
        int seed;
        pv[0] = 8'd0; pv[1] = 8'd13; pv[2] = 8'd14; pv[3] = 8'd3;
        @(negedge clk);
        do_reset();
        // R1 reset state
        cyc(0, 0, 0, 0, 0, 0, 0, "R1");
        // R3 outside window passthrough, with and without code
        cyc(0, 0, 0, 1, 8'd13, 1, 32'hABCD, "R3");
        cyc(0, 0, 0, 1, 8'd6, 0, 32'h1234, "R3");
        // R2 R4 R5: all nine class pairs inside a window
        foreach (pv[i]) begin
            foreach (pv[j]) begin
                cyc(1, pv[i], 0, 0, 0, 0, 0, "R6");
                cyc(0, 0, 0, 1, pv[j], 1, 32'h55, esc(pv[i], pv[j]) ? "R4" : "R5");
                cyc(0, 0, 1, 0, 0, 0, 0, "R6");
            end
        end
        // R2 edges: vector 9 and 15 benign, 10 contributory
        cyc(1, 8'd14, 0, 0, 0, 0, 0, "R2");
        cyc(0, 0, 0, 1, 8'd9, 1, 32'h9, "R2");
        cyc(0, 0, 0, 1, 8'd15, 0, 0, "R2");
        cyc(0, 0, 0, 1, 8'd10, 1, 32'h7, "R2");
        // R6 exc right after done: no window
        cyc(0, 0, 1, 0, 0, 0, 0, "R6");
        cyc(0, 0, 0, 1, 8'd13, 1, 32'h3, "R6");
        // R6 exc same cycle as start judged against closed window
        cyc(1, 8'd13, 0, 1, 8'd13, 1, 32'h4, "R6");
        cyc(0, 0, 0, 1, 8'd13, 1, 32'h4, "R6");
        // R10 start and done together: window open with new vector
        cyc(1, 8'd14, 1, 0, 0, 0, 0, "R10");
        cyc(0, 0, 0, 1, 8'd14, 1, 32'h8, "R10");
        // R7 fault while delivering vector 8
        cyc(1, 8'd8, 0, 0, 0, 0, 0, "R7");
        cyc(0, 0, 0, 1, 8'd3, 0, 0, "R7");
        // R8 sticky and silent
        cyc(0, 0, 1, 1, 8'd6, 1, 32'hFF, "R8");
        cyc(0, 0, 0, 1, 8'd13, 1, 32'hFF, "R8");
        cyc(1, 8'd0, 0, 1, 8'd0, 0, 0, "R8");
        do_reset();
        cyc(0, 0, 0, 0, 0, 0, 0, "R1");
        // Random mix, R9 single pulses
        seed = $urandom(32'd2024);
        for (int k = 0; k < 3000; k++) begin
            logic s, d, e, eh;
            logic [7:0] sv, ev;
            s  = ($urandom % 4) == 0;
            d  = ($urandom % 3) == 0;
            e  = ($urandom % 2) == 0;
            eh = $urandom % 2;
            sv = 8'($urandom % 16);
            ev = 8'($urandom % 16);
            if (m_shut && ($urandom % 8) == 0) do_reset();
            cyc(s, sv, d, e, ev, eh, $urandom, "R9");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule